// File: doc/BRIEF.md
# Sequential Four-Channel Servo Pulse Generator

This block drives up to four hobby servos from a single timing engine. It serves one channel at a time, in a fixed rotation. Each channel gets a slot made of four phases:

- a fixed base high interval;
- an extra high interval set by that channel's position value;
- a low interval that makes up the rest of the variable part;
- a fixed gap of several base intervals.

The sequencer then moves to the next channel. Every slot lasts the same time whatever the position, so the frame rate is fixed and no two outputs are ever high together.

A parameterised clock divider inside the block produces the timing tick. With the defaults (200 clocks per tick at 50 MHz), one tick is 4 µs. A base interval is 2^POS_W ticks, which is 256 ticks or about 1 ms. A position of 0 therefore gives a pulse of about 1 ms, and a position of 255 gives about 2 ms. The block is fed from a register bank that holds the four positions. It samples a channel's position once, at the very start of that channel's slot.

Top module: `servo_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) forces every output low. On the first clock edge after `rst` falls, output bit 0 goes high, and the sequencer restarts at channel 0.
- R2: The internal tick fires once every CLK_DIV clock cycles. All durations below are counted in ticks and equal ticks × CLK_DIV clock cycles.
- R3: The high time of a pulse is B + P + 1 ticks. Here B = 2^POS_W (256 by default) and P is the channel's position. P is taken from bits [c*POS_W +: POS_W] of `pos_i` for channel c.
- R4: Consecutive pulse rising edges, on successive channels, are exactly 5·B + 1 ticks apart for any positions. This total is made up of four parts:
  - the base high interval, B ticks;
  - the extra high interval, P + 1 ticks;
  - the low top-up, B − P ticks;
  - the gap, GAP_UNITS·B ticks (3·B by default).
- R5: Channels are served in the order 0, 1, 2, 3, then 0 again. Channel c drives bit c of `pwm_o`.
- R6: At most one bit of `pwm_o` is high at any time.
- R7: The position is sampled when the channel's slot begins. A change of `pos_i` during the slot alters neither that pulse nor that slot's length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pos_i | input | N_CH*POS_W | Packed positions, channel c at [c*POS_W +: POS_W] |
| pwm_o | output | N_CH | Servo pulse outputs, bit c for channel c |

## Verification
The bench sweeps every position value of a narrow configuration on every channel. It also scrambles each channel's position while that channel's pulse is high.

- A design that sampled the position late would produce pulse widths matching the scrambled value.
- A design with an off-by-one in the extra or top-up phase would show wrong widths at positions 0 and maximum, and uneven rise-to-rise spacing.
- A wrong channel advance would break the expected output order.

A reset in mid-pulse checks that the active output drops at once and that the rotation restarts on channel 0 rather than resuming where it stopped.

// File: rtl/servo_seq.sv
module servo_seq #(
  parameter int CLK_DIV   = 200,
  parameter int POS_W     = 8,
  parameter int N_CH      = 4,
  parameter int GAP_UNITS = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_CH*POS_W-1:0]   pos_i,
  output logic [N_CH-1:0]         pwm_o
);
  localparam int BASE  = 1 << POS_W;
  localparam int CNT_W = $clog2(GAP_UNITS * BASE);
  localparam int CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1;
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  typedef enum logic [1:0] {PH_HI = 2'd0, PH_EXT = 2'd1, PH_LO = 2'd2, PH_GAP = 2'd3} phase_t;

  logic             tick;
  phase_t           phase_q;
  logic [CH_W-1:0]  ch_q, ch_nx;
  logic [CNT_W-1:0] cnt_q;
  logic [POS_W-1:0] pos_lat_q, pos_nx;
  logic [N_CH-1:0]  sel, pwm_q;
  logic             last;

  generate
    if (CLK_DIV > 1) begin : g_div
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= (div_q == DIV_W'(CLK_DIV - 1)) ? '0 : div_q + 1'b1;
      end
      assign tick = (div_q == DIV_W'(CLK_DIV - 1));

      // R2
      tick_gap_chk: assert property (@(posedge clk) disable iff (rst) tick |=> !tick);
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  assign last   = (cnt_q == '0);
  assign ch_nx  = (ch_q == CH_W'(N_CH - 1)) ? '0 : ch_q + 1'b1;
  assign pos_nx = pos_i[ch_nx*POS_W +: POS_W];

  always_comb begin
    for (int i = 0; i < N_CH; i++) sel[i] = (ch_q == CH_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_HI;
      ch_q      <= '0;
      cnt_q     <= CNT_W'(BASE - 1);
      pos_lat_q <= pos_i[POS_W-1:0];
      pwm_q     <= '0;
    end else begin
      pwm_q <= (phase_q == PH_HI || phase_q == PH_EXT) ? sel : '0;
      if (tick) begin
        if (!last) begin
          cnt_q <= cnt_q - 1'b1;
        end else begin
          case (phase_q)
            PH_HI: begin
              phase_q <= PH_EXT;
              cnt_q   <= CNT_W'(pos_lat_q);
            end
            PH_EXT: begin
              phase_q <= PH_LO;
              cnt_q   <= CNT_W'(BASE - 1) - CNT_W'(pos_lat_q);
            end
            PH_LO: begin
              phase_q <= PH_GAP;
              cnt_q   <= CNT_W'(GAP_UNITS * BASE - 1);
            end
            PH_GAP: begin
              phase_q   <= PH_HI;
              ch_q      <= ch_nx;
              cnt_q     <= CNT_W'(BASE - 1);
              pos_lat_q <= pos_nx;
            end
          endcase
        end
      end
    end
  end

  assign pwm_o = pwm_q;

  // R1
  reset_low_chk: assert property (@(posedge clk) rst |=> (pwm_q == '0));

  // R3
  ext_len_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_EXT && $past(phase_q) == PH_HI) |-> (cnt_q == CNT_W'(pos_lat_q)));

  // R4
  slot_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_LO && $past(phase_q) == PH_EXT) |-> (int'(cnt_q) + int'(pos_lat_q) == BASE - 1));

  // R5
  order_chk: assert property (@(posedge clk) disable iff (rst)
    (ch_q != $past(ch_q)) |-> (ch_q == (($past(ch_q) == CH_W'(N_CH - 1)) ? '0 : $past(ch_q) + 1'b1)));

  // R6
  single_out_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(pwm_q));

  // R7
  pos_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q != PH_HI || $past(phase_q) == PH_HI) |-> $stable(pos_lat_q));
endmodule

// File: tb/servo_seq_tb.sv
`timescale 1ns/1ps
module servo_seq_tb_top;
  localparam int DIV  = 3;
  localparam int PW   = 4;
  localparam int NC   = 4;
  localparam int GAPU = 3;
  localparam int B    = 1 << PW;
  localparam int SLOT = (2 + GAPU) * B + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [PW-1:0] pv [NC];
  logic [NC*PW-1:0] pos_i;
  logic [NC-1:0] pwm_o;

  int checks = 0;
  int errors = 0;
  longint cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign pos_i = {pv[3], pv[2], pv[1], pv[0]};

  servo_seq #(.CLK_DIV(DIV), .POS_W(PW), .N_CH(NC), .GAP_UNITS(GAPU)) dut_i (
    .clk(clk), .rst(rst), .pos_i(pos_i), .pwm_o(pwm_o));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] sweep(input int f, input int c);
    return PW'((f * 7 + c * 4) % B);
  endfunction

  logic [NC-1:0] prev = '0;
  logic [NC-1:0] hv = '0;
  longint rise_cyc [NC];
  int exp_pos [NC];
  longint last_rise = 0;
  bit have_prev = 0;
  int exp_ch = 0;

  always @(negedge clk) begin
    if (rst) begin
      have_prev = 0;
      exp_ch = 0;
      hv = '0;
    end else begin
      if (!$onehot0(pwm_o)) chk(0, "R6 single output", $countones(pwm_o), 1);
      for (int c = 0; c < NC; c++) begin
        if (pwm_o[c] && !prev[c]) begin
          chk(c == exp_ch, "R5 channel order", c, exp_ch);
          chk($countones(pwm_o) == 1, "R6 one high", $countones(pwm_o), 1);
          if (have_prev) chk(cyc - last_rise == SLOT * DIV, "R4 slot length", cyc - last_rise, SLOT * DIV);
          last_rise = cyc;
          have_prev = 1;
          exp_ch = (c + 1) % NC;
          rise_cyc[c] = cyc;
          exp_pos[c] = int'(pv[c]);
          hv[c] = 1'b1;
        end
        if (!pwm_o[c] && prev[c] && hv[c]) begin
          chk(cyc - rise_cyc[c] == (B + 1 + exp_pos[c]) * DIV, "R3 R7 R2 high width",
              cyc - rise_cyc[c], (B + 1 + exp_pos[c]) * DIV);
          hv[c] = 1'b0;
        end
      end
    end
    prev = pwm_o;
  end

  initial begin
    for (int c = 0; c < NC; c++) pv[c] = sweep(0, c);
    repeat (4) @(negedge clk);
    chk(pwm_o == '0, "R1 low in reset", pwm_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(pwm_o == 4'b0001, "R1 channel 0 first", pwm_o, 1);
    for (int f = 0; f < B; f++) begin
      for (int c = 0; c < NC; c++) begin
        while (!pwm_o[c]) @(negedge clk);
        repeat (4) @(negedge clk);
        pv[c] = ~pv[c];
        while (pwm_o[c]) @(negedge clk);
        pv[c] = sweep(f + 1, c);
      end
    end
    while (!pwm_o[2]) @(negedge clk);
    repeat (10) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(pwm_o == '0, "R1 mid-pulse reset", pwm_o, 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(pwm_o == 4'b0001, "R1 restart on channel 0", pwm_o, 1);
    while (!pwm_o[1]) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule